// File: doc/BRIEF.md
# Segmented Load Sequencer

This block is a minimal instruction sequencer that steps through a fetch, decode and execute loop against a byte-wide synchronous memory. It keeps a code segment, a data segment, an instruction offset and an 8-bit accumulator. Every memory address it issues is a 20-bit physical address formed from a 16-bit segment and a 16-bit offset. The segment is multiplied by 16, the offset is added, and the sum wraps modulo 2^20.

Only one instruction is recognised: a three-byte accumulator load. Its opcode is A0h, and the next two bytes hold a 16-bit data offset with the low byte first. The sequencer fetches the three bytes from the code segment, assembles the offset and reads one byte from the data segment into the accumulator. It then moves the instruction offset past the instruction. Any other opcode stops the sequencer for good and raises an error output, which only a reset clears.

Top module: `fx_exec_unit`

## Requirements
- R1: Every issued address on `mem_addr_o` equals (segment * 16 + offset) modulo 2^20, with segment and offset both 16 bits. For example, segment FFFEh with offset 0021h gives 00001h.
- R2: An instruction's bytes are read at CS:IP, CS:IP+1 and CS:IP+2 in three consecutive cycles. Read data returns on `mem_rdata_i` one cycle after the cycle in which `mem_rd_o` is high.
- R3: For opcode A0h, the data read is issued in the cycle right after the third byte is fetched. Its address is DS:{third byte, second byte}, so the second byte is the low byte of the offset. For example, DS 05D1h with offset 0016h reads 05D26h.
- R4: The byte returned by the data read appears on `al_o` two cycles after that read is issued. `al_o` changes at no other time.
- R5: After a load, IP has advanced by 3. The next opcode fetch is issued two cycles after the data read. `mem_rd_o` is low in the cycle between those two reads.
- R6: After reset, IP is 0, CS and DS hold the parameters `CS_RESET` and `DS_RESET`, and `al_o` and `err_o` are 0. The first read goes to `CS_RESET`:0000h.
- R7: For any opcode other than A0h, `err_o` rises two cycles after that opcode's fetch. From then until the next reset, `mem_rd_o` stays low, `err_o` stays high and `al_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 20 | Physical read address |
| mem_rdata_i | input | 8 | Read data, one cycle after the strobe |
| al_o | output | 8 | Accumulator contents |
| err_o | output | 1 | Sticky halt on unknown opcode |

## Verification
A wrong state or a bad IP shows up at once as a read address that does not match the expected sequence. A fault in offset assembly or byte order appears on the fourth read of the instruction that suffers it. A wrong accumulator load is visible on `al_o` two cycles after the data read. A wrong decision at decode shows up within two cycles of the opcode fetch, either as a spurious read or as `err_o` at the wrong time. The program is placed so that instruction bytes straddle the top of the 20-bit space, which exposes address sums that do not wrap.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef enum logic [2:0] {
    ST_OPC   = 3'd0,  // issue opcode fetch
    ST_DEC   = 3'd1,  // opcode arrives, fetch offset low
    ST_OFFLO = 3'd2,  // offset low arrives, fetch offset high
    ST_OFFHI = 3'd3,  // offset high arrives, issue data read
    ST_EXE   = 3'd4,  // data arrives, write back, step IP
    ST_HALT  = 3'd5
  } fx_state_e;

  localparam logic [7:0] OPC_LD_ACC = 8'hA0;
endpackage

// File: rtl/fx_agen.sv
module fx_agen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o
);
  // sum truncates to PA_W bits: wraps at top of space
  assign pa_o = {seg_i, {SHIFT{1'b0}}} + PA_W'(off_i);
endmodule

// File: rtl/fx_decode.sv
module fx_decode #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opc_i,
  output logic              is_load_o
);
  assign is_load_o = (opc_i == DATA_W'(fx_pkg::OPC_LD_ACC));
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
#(
  parameter int              SEG_W    = 16,
  parameter int              OFF_W    = 16,
  parameter int              DATA_W   = 8,
  parameter logic [SEG_W-1:0] CS_RESET = '0,
  parameter logic [SEG_W-1:0] DS_RESET = '0,
  localparam int             INSN_LEN = 1 + OFF_W / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              is_load_i,
  output logic              rd_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              err_o,
  output fx_state_e         state_o,
  output logic [OFF_W-1:0]  ip_o
);
  fx_state_e                 state_q;
  logic [SEG_W-1:0]          cs_q, ds_q;
  logic [OFF_W-1:0]          ip_q;
  logic [DATA_W-1:0]         acc_q, off_lo_q;

  always_comb begin
    rd_o  = 1'b0;
    seg_o = cs_q;
    off_o = ip_q;
    unique case (state_q)
      ST_OPC:   rd_o = 1'b1;
      ST_DEC: begin
        rd_o  = is_load_i;
        off_o = ip_q + OFF_W'(1);
      end
      ST_OFFLO: begin
        rd_o  = 1'b1;
        off_o = ip_q + OFF_W'(2);
      end
      ST_OFFHI: begin
        rd_o  = 1'b1;
        seg_o = ds_q;
        off_o = OFF_W'({rdata_i, off_lo_q});  // low byte came first
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPC;
      cs_q     <= CS_RESET;
      ds_q     <= DS_RESET;
      ip_q     <= '0;
      acc_q    <= '0;
      off_lo_q <= '0;
    end else begin
      unique case (state_q)
        ST_OPC:   state_q <= ST_DEC;
        ST_DEC:   state_q <= is_load_i ? ST_OFFLO : ST_HALT;
        ST_OFFLO: begin
          off_lo_q <= rdata_i;
          state_q  <= ST_OFFHI;
        end
        ST_OFFHI: state_q <= ST_EXE;
        ST_EXE: begin
          acc_q   <= rdata_i;
          ip_q    <= ip_q + OFF_W'(INSN_LEN);
          state_q <= ST_OPC;
        end
        default:  state_q <= ST_HALT;
      endcase
    end
  end

  assign acc_o   = acc_q;
  assign err_o   = (state_q == ST_HALT);
  assign state_o = state_q;
  assign ip_o    = ip_q;
endmodule

// File: rtl/fx_exec_unit.sv
module fx_exec_unit
  import fx_pkg::*;
#(
  parameter int               SEG_W    = 16,
  parameter int               OFF_W    = 16,
  parameter int               DATA_W   = 8,
  parameter int               SHIFT    = 4,
  parameter logic [SEG_W-1:0] CS_RESET = 16'h0000,
  parameter logic [SEG_W-1:0] DS_RESET = 16'h0000,
  localparam int              PA_W     = SEG_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] al_o,
  output logic              err_o
);
  logic             is_load;
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] ip;
  fx_state_e        state;

  fx_decode #(.DATA_W(DATA_W)) u_dec (
    .opc_i     (mem_rdata_i),
    .is_load_o (is_load)
  );

  fx_ctrl #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .CS_RESET(CS_RESET), .DS_RESET(DS_RESET)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdata_i   (mem_rdata_i),
    .is_load_i (is_load),
    .rd_o      (mem_rd_o),
    .seg_o     (seg),
    .off_o     (off),
    .acc_o     (al_o),
    .err_o     (err_o),
    .state_o   (state),
    .ip_o      (ip)
  );

  fx_agen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_agen (
    .seg_i (seg),
    .off_i (off),
    .pa_o  (mem_addr_o)
  );
endmodule

// File: rtl/fx_exec_unit_chk.sv
module fx_exec_unit_chk
  import fx_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input fx_state_e         state_i,
  input logic [OFF_W-1:0]  ip_i,
  input logic              mem_rd_i,
  input logic [DATA_W-1:0] al_i,
  input logic              err_i
);
  AST_OPC_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OPC) |-> mem_rd_i);  // R2
  AST_DATA_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OFFHI) |-> mem_rd_i);  // R3
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_EXE) |=> $stable(al_i));  // R4
  AST_IP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXE) |=> (ip_i == $past(ip_i) + OFF_W'(3)));  // R5
  AST_EXE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXE) |-> !mem_rd_i);  // R5
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !mem_rd_i);  // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (err_i && $stable(al_i)));  // R7
endmodule

bind fx_exec_unit fx_exec_unit_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state),
  .ip_i     (ip),
  .mem_rd_i (mem_rd_o),
  .al_i     (al_o),
  .err_i    (err_o)
);

// File: tb/tb_fx_exec_unit.sv
module tb_fx_exec_unit;
  localparam int         CLK_PERIOD = 10;
  localparam logic [15:0] CS_RST = 16'hFFFE;
  localparam logic [15:0] DS_RST = 16'h05D1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [19:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  al;
  logic        err;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_exec_unit #(.CS_RESET(CS_RST), .DS_RESET(DS_RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .al_o(al), .err_o(err)
  );

  logic [7:0] mem [logic [19:0]];
  always @(posedge clk)
    if (mem_rd) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;

  // kind: 0 address only, 1 then check accumulator, 2 then check error rise
  typedef struct {
    logic [19:0] addr;
    int          kind;
    logic [7:0]  val;
    string       req;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_err = 0;
  int pend = 0, pend_kind = 0;
  logic [7:0] pend_val;
  logic [15:0] ip_m;
  bit finished = 0;

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [19:0] a, int k, logic [7:0] v, string r);
    item_t it;
    it.addr = a; it.kind = k; it.val = v; it.req = r;
    q.push_back(it);
  endtask

  // driver: place one load in memory and queue its expected reads
  task automatic put_load(logic [15:0] off, logic [7:0] data);
    mem[phys(CS_RST, ip_m)]                = 8'hA0;
    mem[phys(CS_RST, ip_m + 16'd1)]        = off[7:0];
    mem[phys(CS_RST, ip_m + 16'd2)]        = off[15:8];
    mem[phys(DS_RST, off)]                 = data;
    push(phys(CS_RST, ip_m), 0, 0, "R2");
    push(phys(CS_RST, ip_m + 16'd1), 0, 0, "R1");
    push(phys(CS_RST, ip_m + 16'd2), 0, 0, "R2");
    push(phys(DS_RST, off), 1, data, "R3");
    ip_m = ip_m + 16'd3;  // R5
  endtask

  task automatic put_bad(logic [7:0] opc);
    mem[phys(CS_RST, ip_m)] = opc;
    push(phys(CS_RST, ip_m), 2, 0, "R7");
  endtask

  // monitor: compare every read and timed results against the queue
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pend > 0) begin
        pend--;
        if (pend_kind == 1 && pend == 0) begin
          check(al == pend_val, "R4", "al_o", al, pend_val);
          check(err == 1'b0, "R4", "err_o during run", err, 0);
        end
        if (pend_kind == 2 && pend == 1)
          check(err == 1'b0, "R7", "err_o early", err, 0);
        if (pend_kind == 2 && pend == 0)
          check(err == 1'b1, "R7", "err_o rise", err, 1);
      end
      if (mem_rd) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "unexpected read", mem_addr, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(mem_addr == it.addr, it.req, "read address", mem_addr, it.addr);
          if (it.kind != 0) begin
            pend = 2; pend_kind = it.kind; pend_val = it.val;
          end
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    q.delete();
    pend = 0;
    mem.delete();
    ip_m = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(al == 8'h00, "R6", "al_o reset", al, 0);
    check(err == 1'b0, "R6", "err_o reset", err, 0);
    check(mem_addr == phys(CS_RST, 16'h0), "R6", "reset address", mem_addr, phys(CS_RST, 16'h0));
  endtask

  task automatic run_to_end();
    @(negedge clk);
    rst_n = 1'b1;
    while (q.size() != 0 || pend != 0) @(posedge clk);
  endtask

  task automatic check_halt(logic [7:0] exp_al);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(err == 1'b1, "R7", "err_o held", err, 1);
    check(mem_rd == 1'b0, "R7", "read while halted", mem_rd, 0);
    check(al == exp_al, "R7", "al_o held in halt", al, exp_al);
    check(q.size() == 0, "R7", "pending reads", q.size(), 0);
  endtask

  initial begin
    // phase 1: loads straddling the top of the address space
    do_reset();
    put_load(16'h0016, 8'h4A);  // R3 example: 05D1:0016 -> 05D26
    for (int k = 1; k < 11; k++)
      put_load((k == 3) ? 16'hFFFF : 16'h0016 + 16'(k) * 16'h1111, 8'h10 + 8'(k * 7));
    put_bad(8'h90);
    run_to_end();
    check_halt(8'h10 + 8'(10 * 7));

    // phase 2: near-miss opcode after one load
    do_reset();
    put_load(16'h00FE, 8'hC3);
    put_bad(8'hA1);
    run_to_end();
    check_halt(8'hC3);

    // phase 3: bad opcode first, accumulator untouched
    do_reset();
    put_bad(8'h00);
    run_to_end();
    check_halt(8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule